// File: doc/BRIEF.md
# In-Band Stop/Resume Flow-Control Gate

This block sits on a full-duplex byte link between the local byte producer, the serial transmitter and the receive path. It applies in-band flow control in both directions. When the far end sends the halt code, the block stops taking bytes from the local producer. When the far end sends the resume code, the block starts taking them again. The two codes never reach the local receive output.

On the local side the block watches the fill level of the receive buffer. It injects a halt code when the level reaches a high mark. It injects a resume code once the level falls below a lower mark, so the gap between the two marks gives hysteresis.

The block also covers the weak points of single-character flow control with three re-send rules:
- One resume code is sent right after reset.
- A resume code is sent again after a long quiet spell on the receive side.
- A halt code is sent again for every few data bytes that still arrive after a halt.

Injected codes go ahead of producer bytes. A byte already offered to the transmitter is never withdrawn.

Top module: `sw_flow_gate`

## Requirements
- R1: While reset is held, txValid and fwdValid are low. The first byte offered on the transmit port after reset is the resume code (RESUME_CODE, default 0x11).
- R2: The block starts in the state where the far end allows sending. A received byte equal to HALT_CODE (default 0x13) drives srcReady low from the next cycle on. srcReady stays low until a byte equal to RESUME_CODE is received.
- R3: A received byte equal to either code never appears on fwdValid/fwdData. Any other received byte appears on fwdValid/fwdData exactly one cycle after its rxStrobe.
- R4: When bufLevel rises to HI_MARK (default 12) or above, exactly one halt code is sent. A level that stays high sends no further halt code by itself. A level of HI_MARK-1 sends none.
- R5: After a halt, a resume code is sent only when bufLevel drops below LO_MARK (default 4). Levels from LO_MARK up to HI_MARK-1 send no code.
- R6: While locally halted, each group of RETRY_BYTES (default 4) received data bytes, counted after the last halt code left, causes one further halt code. Fewer bytes cause none.
- R7: While not locally halted and with no resume pending, IDLE_CYCLES (default 200) cycles without any received byte cause one resume code. The code is offered about two cycles after the quiet spell ends.
- R8: Pending halt or resume codes are offered before producer bytes, and a pending halt goes before a pending resume. While txValid is high and txReady is low, txData holds steady.
- R9: Producer bytes are taken only when srcValid and srcReady are both high. They reach the transmit port unchanged and in order, on the cycle after they are taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Local producer has a byte |
| srcData | input | 8 | Local producer byte |
| srcReady | output | 1 | Block takes the producer byte this cycle |
| txValid | output | 1 | Byte offered to the serial transmitter |
| txData | output | 8 | Offered byte |
| txReady | input | 1 | Transmitter takes the offered byte |
| rxStrobe | input | 1 | One received byte is present |
| rxByte | input | 8 | Received byte |
| fwdValid | output | 1 | Forwarded received data byte is valid |
| fwdData | output | 8 | Forwarded received data byte |
| bufLevel | input | LVL_W | Fill level of the local receive buffer |

## Verification
Each result has a fixed latency:
- A received byte shows up on the forward port one cycle after its strobe.
- A received halt code lowers srcReady one cycle later.
- A threshold crossing or a retry condition sets a pending flag on the next edge. The code is offered on the edge after that.
- An idle resume appears about IDLE_CYCLES+2 cycles after the last received byte.

The bench drives inputs just after the rising edge and records every handshake at the falling edge. The directed checks therefore compare either exact orderings or windows that are only a few cycles wide around those latencies. The random phase compares whole logged streams against queues of expected bytes built by the bench.

// File: rtl/flow_pkg.sv
package flow_pkg;
  // control -> datapath
  typedef struct packed {
    logic haltPend;
    logic resumePend;
    logic remoteGo;
  } ctlReq_t;

  // datapath -> control
  typedef struct packed {
    logic haltSent;
    logic resumeSent;
    logic gotHalt;
    logic gotResume;
    logic gotData;
  } dpEvt_t;
endpackage

// File: rtl/flow_dp.sv
module flow_dp
  import flow_pkg::*;
#(
  parameter logic [7:0] HALT_CODE   = 8'h13,
  parameter logic [7:0] RESUME_CODE = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctlReq_t    req,
  output dpEvt_t     evt,
  input  logic       srcValid,
  input  logic [7:0] srcData,
  output logic       srcReady,
  output logic       txValid,
  output logic [7:0] txData,
  input  logic       txReady,
  input  logic       rxStrobe,
  input  logic [7:0] rxByte,
  output logic       fwdValid,
  output logic [7:0] fwdData
);
  logic loadSlot;
  logic rxIsHalt;
  logic rxIsResume;

  always_comb begin
    loadSlot       = !txValid || txReady;
    rxIsHalt       = rxStrobe && (rxByte == HALT_CODE);
    rxIsResume     = rxStrobe && (rxByte == RESUME_CODE);
    srcReady       = loadSlot && !req.haltPend && !req.resumePend && req.remoteGo;
    evt.haltSent   = loadSlot && req.haltPend;
    evt.resumeSent = loadSlot && !req.haltPend && req.resumePend;
    evt.gotHalt    = rxIsHalt;
    evt.gotResume  = rxIsResume;
    evt.gotData    = rxStrobe && !rxIsHalt && !rxIsResume;
  end

  // transmit slot: injected codes first, then producer bytes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txValid <= 1'b0;
      txData  <= '0;
    end else if (loadSlot) begin
      if (req.haltPend) begin
        txValid <= 1'b1;
        txData  <= HALT_CODE;
      end else if (req.resumePend) begin
        txValid <= 1'b1;
        txData  <= RESUME_CODE;
      end else if (srcValid && req.remoteGo) begin
        txValid <= 1'b1;
        txData  <= srcData;
      end else begin
        txValid <= 1'b0;
      end
    end
  end

  // receive filter: control codes are consumed
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwdValid <= 1'b0;
      fwdData  <= '0;
    end else begin
      fwdValid <= evt.gotData;
      if (evt.gotData) fwdData <= rxByte;
    end
  end
endmodule

// File: rtl/flow_ctl.sv
module flow_ctl
  import flow_pkg::*;
#(
  parameter int LVL_W       = 5,
  parameter int HI_MARK     = 12,
  parameter int LO_MARK     = 4,
  parameter int IDLE_CYCLES = 200,
  parameter int RETRY_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] bufLevel,
  input  dpEvt_t           evt,
  output ctlReq_t          req
);
  localparam int IDLE_W  = $clog2(IDLE_CYCLES + 1);
  localparam int RETRY_W = $clog2(RETRY_BYTES + 1);
  localparam logic [LVL_W-1:0]   HI_LVL    = LVL_W'(HI_MARK);
  localparam logic [LVL_W-1:0]   LO_LVL    = LVL_W'(LO_MARK);
  localparam logic [IDLE_W-1:0]  IDLE_LAST = IDLE_W'(IDLE_CYCLES - 1);
  localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(RETRY_BYTES - 1);

  logic localHalted;
  logic pendHalt;
  logic pendResume;
  logic remoteGo;
  logic [IDLE_W-1:0]  idleCnt;
  logic [RETRY_W-1:0] retryCnt;

  logic anyRx;
  logic highEvt, lowEvt, idleFire, retryFire, haltEvt, resumeEvt;

  always_comb begin
    anyRx     = evt.gotHalt || evt.gotResume || evt.gotData;
    highEvt   = !localHalted && (bufLevel >= HI_LVL);
    lowEvt    = localHalted && (bufLevel < LO_LVL);
    idleFire  = !localHalted && !pendResume && !anyRx && (idleCnt == IDLE_LAST);
    retryFire = localHalted && !pendHalt && evt.gotData && (retryCnt == RETRY_LAST);
    haltEvt   = highEvt || retryFire;
    resumeEvt = lowEvt || idleFire;
    req.haltPend   = pendHalt;
    req.resumePend = pendResume;
    req.remoteGo   = remoteGo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      localHalted <= 1'b0;
      pendHalt    <= 1'b0;
      pendResume  <= 1'b1;   // announce readiness after reset
      remoteGo    <= 1'b1;
      idleCnt     <= '0;
      retryCnt    <= '0;
    end else begin
      if (highEvt)     localHalted <= 1'b1;
      else if (lowEvt) localHalted <= 1'b0;

      pendHalt   <= haltEvt || (pendHalt && !evt.haltSent && !resumeEvt);
      pendResume <= resumeEvt || (pendResume && !evt.resumeSent && !haltEvt);

      if (evt.gotHalt)        remoteGo <= 1'b0;
      else if (evt.gotResume) remoteGo <= 1'b1;

      if (localHalted || pendResume || anyRx || idleFire) idleCnt <= '0;
      else idleCnt <= idleCnt + 1'b1;

      if (!localHalted || pendHalt || retryFire) retryCnt <= '0;
      else if (evt.gotData) retryCnt <= retryCnt + 1'b1;
    end
  end
endmodule

// File: rtl/sw_flow_gate.sv
module sw_flow_gate
  import flow_pkg::*;
#(
  parameter int         LVL_W       = 5,
  parameter int         HI_MARK     = 12,
  parameter int         LO_MARK     = 4,
  parameter int         IDLE_CYCLES = 200,
  parameter int         RETRY_BYTES = 4,
  parameter logic [7:0] HALT_CODE   = 8'h13,
  parameter logic [7:0] RESUME_CODE = 8'h11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srcValid,
  input  logic [7:0]       srcData,
  output logic             srcReady,
  output logic             txValid,
  output logic [7:0]       txData,
  input  logic             txReady,
  input  logic             rxStrobe,
  input  logic [7:0]       rxByte,
  output logic             fwdValid,
  output logic [7:0]       fwdData,
  input  logic [LVL_W-1:0] bufLevel
);
  ctlReq_t req;
  dpEvt_t  evt;

  flow_ctl #(
    .LVL_W(LVL_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK),
    .IDLE_CYCLES(IDLE_CYCLES), .RETRY_BYTES(RETRY_BYTES)
  ) i_ctl (
    .clk(clk), .rst_n(rst_n), .bufLevel(bufLevel), .evt(evt), .req(req)
  );

  flow_dp #(
    .HALT_CODE(HALT_CODE), .RESUME_CODE(RESUME_CODE)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .req(req), .evt(evt),
    .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxStrobe(rxStrobe), .rxByte(rxByte),
    .fwdValid(fwdValid), .fwdData(fwdData)
  );
endmodule

// File: rtl/flow_chk.sv
module flow_chk #(
  parameter logic [7:0] HALT_CODE   = 8'h13,
  parameter logic [7:0] RESUME_CODE = 8'h11
) (
  input logic       clk,
  input logic       rst_n,
  input logic       srcValid,
  input logic [7:0] srcData,
  input logic       srcReady,
  input logic       txValid,
  input logic [7:0] txData,
  input logic       txReady,
  input logic       rxStrobe,
  input logic [7:0] rxByte,
  input logic       fwdValid,
  input logic [7:0] fwdData
);
  p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && !txReady) |=> (txValid && $stable(txData)));

  p_code_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && (rxByte == HALT_CODE || rxByte == RESUME_CODE)) |=> !fwdValid);

  p_data_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && rxByte != HALT_CODE && rxByte != RESUME_CODE)
      |=> (fwdValid && fwdData == $past(rxByte)));

  p_src_to_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (srcValid && srcReady) |=> (txValid && txData == $past(srcData)));

  p_remote_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rxStrobe && rxByte == HALT_CODE) |=> !srcReady);
endmodule

bind sw_flow_gate flow_chk #(.HALT_CODE(HALT_CODE), .RESUME_CODE(RESUME_CODE)) i_flow_chk (
  .clk(clk), .rst_n(rst_n), .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
  .txValid(txValid), .txData(txData), .txReady(txReady), .rxStrobe(rxStrobe),
  .rxByte(rxByte), .fwdValid(fwdValid), .fwdData(fwdData)
);

// File: tb/test_sw_flow_gate.sv
module test_sw_flow_gate;
  localparam logic [7:0] HALT = 8'h13;
  localparam logic [7:0] RES  = 8'h11;
  localparam int IDLE = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srcValid = 1'b0;
  logic [7:0] srcData = '0;
  logic srcReady;
  logic txValid;
  logic [7:0] txData;
  logic txReady = 1'b0;
  logic rxStrobe = 1'b0;
  logic [7:0] rxByte = '0;
  logic fwdValid;
  logic [7:0] fwdData;
  logic [4:0] bufLevel = '0;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] txLog[$];
  logic [7:0] srcLog[$];
  logic [7:0] fwdLog[$];
  logic [7:0] expFwd[$];
  logic [7:0] txData_q[$];

  always #2ns clk = ~clk;   // 250 MHz

  sw_flow_gate i_sw_flow_gate (
    .clk(clk), .rst_n(rst_n), .srcValid(srcValid), .srcData(srcData), .srcReady(srcReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .rxStrobe(rxStrobe),
    .rxByte(rxByte), .fwdValid(fwdValid), .fwdData(fwdData), .bufLevel(bufLevel)
  );

  always @(negedge clk) if (rst_n) begin
    if (txValid && txReady) txLog.push_back(txData);
    if (srcValid && srcReady) srcLog.push_back(srcData);
    if (fwdValid) fwdLog.push_back(fwdData);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1ns;
  endtask

  function automatic int countOf(input logic [7:0] v);
    int c = 0;
    foreach (txLog[i]) if (txLog[i] == v) c++;
    return c;
  endfunction

  function automatic bit isCode(input logic [7:0] b);
    return (b == HALT) || (b == RES);
  endfunction

  task automatic rxSend(input logic [7:0] b);
    rxStrobe = 1'b1; rxByte = b;
    tick(1);
    rxStrobe = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #400000ns;
    check(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    void'($urandom(32'd7));
    tick(3);
    // R1: reset state
    check(!txValid && !fwdValid, "R1 reset outputs", {txValid, fwdValid}, 0);
    rst_n = 1'b1;
    tick(3);
    check(txValid && txData == RES, "R1 first byte is resume", txData, RES);

    // R8/R4: resume held, halt raised, producer waits
    bufLevel = 5'd14; srcValid = 1'b1; srcData = 8'h5A;
    tick(4);
    check(!srcReady, "R8 producer held while codes pending", srcReady, 0);
    txReady = 1'b1;
    while (srcLog.size() == 0) tick(1);
    srcValid = 1'b0;
    tick(4);
    check(txLog.size() == 3 && txLog[0] == RES && txLog[1] == HALT && txLog[2] == 8'h5A,
          "R8 order resume,halt,data", txLog.size(), 3);

    // R4: staying high sends no more halts
    tick(20);
    check(countOf(HALT) == 1, "R4 single halt", countOf(HALT), 1);

    // R5: hysteresis
    txLog.delete();
    bufLevel = 5'd8; tick(10);
    check(txLog.size() == 0, "R5 mid level silent", txLog.size(), 0);
    bufLevel = 5'd3; tick(5);
    check(txLog.size() == 1 && txLog[0] == RES, "R5 resume below low mark", txLog.size(), 1);

    // R4: threshold edge
    txLog.delete();
    bufLevel = 5'd11; tick(10);
    check(txLog.size() == 0, "R4 level 11 no halt", txLog.size(), 0);
    bufLevel = 5'd12; tick(3);
    check(txLog.size() == 1 && txLog[0] == HALT, "R4 halt at 12 within 3 cycles", txLog.size(), 1);

    // R6: retry halt while data keeps arriving
    txLog.delete(); fwdLog.delete();
    for (int i = 0; i < 3; i++) begin rxSend(8'hA0 + 8'(i)); tick(1); end
    tick(4);
    check(countOf(HALT) == 0, "R6 no retry before 4 bytes", countOf(HALT), 0);
    rxSend(8'hA3); tick(4);
    check(countOf(HALT) == 1, "R6 retry halt after 4 bytes", countOf(HALT), 1);
    check(fwdLog.size() == 4 && fwdLog[3] == 8'hA3, "R3 data bytes forwarded", fwdLog.size(), 4);
    bufLevel = 5'd0; tick(5);

    // R2/R3: remote halt and resume
    fwdLog.delete(); srcLog.delete();
    rxSend(HALT); tick(1);
    srcValid = 1'b1; srcData = 8'h3C;
    tick(20);
    check(srcLog.size() == 0, "R2 producer stopped after halt code", srcLog.size(), 0);
    rxSend(RES); tick(2);
    check(srcLog.size() > 0, "R2 producer resumed", srcLog.size(), 1);
    srcValid = 1'b0; tick(2);
    check(fwdLog.size() == 0, "R3 codes not forwarded", fwdLog.size(), 0);

    // R9/R3: random traffic
    txLog.delete(); srcLog.delete(); fwdLog.delete(); expFwd.delete();
    for (int i = 0; i < 400; i++) begin
      logic [7:0] b;
      srcValid = ($urandom % 2) == 1;
      do b = 8'($urandom); while (isCode(b));
      srcData = b;
      txReady = ($urandom % 4) != 0;
      rxStrobe = ($urandom % 3) == 0;
      if ($urandom % 8 == 0) rxByte = RES;
      else begin do b = 8'($urandom); while (isCode(b)); rxByte = b; end
      if (rxStrobe && rxByte != RES) expFwd.push_back(rxByte);
      tick(1);
    end
    srcValid = 1'b0; rxStrobe = 1'b0; txReady = 1'b1;
    tick(10);
    txData_q.delete();
    foreach (txLog[i]) if (!isCode(txLog[i])) txData_q.push_back(txLog[i]);
    check(txData_q == srcLog && srcLog.size() > 20, "R9 tx stream equals producer stream",
          txData_q.size(), srcLog.size());
    check(fwdLog == expFwd, "R3 forwarded stream", fwdLog.size(), expFwd.size());

    // R7: idle resume
    begin
      int n = 0;
      rxSend(8'h77);
      txLog.delete();
      while (countOf(RES) == 0 && n < 400) begin @(negedge clk); n++; end
      check(n >= IDLE && n <= IDLE + 4, "R7 idle resume timing", n, IDLE + 2);
    end
    summary();
  end
endmodule